// File: doc/BRIEF.md
# Adaptive-Gain Frequency Search Controller

This controller sits between a cyclic phase detector and the oscillator tuning logic of a digital frequency synthesizer. Every valid reference sample carries a phase code in the range 0 to NPH-1. The block sorts each change of code into a forward or a backward transition. It counts these over a measurement window whose length in valid samples is set by software. When a window closes, it issues one request to raise or lower the frequency, together with a step-size code.

When the window holds many transitions, the frequency offset is large. The block then works in high-gain mode and picks a coarse step from the transition count. When the count falls below a programmable threshold, it changes to low-gain mode. There it measures how many reference samples the phase code stays in one state and picks one of four small steps from that width. When a low-gain window sees the code move both ways, the loop is dithering around lock. The block then asks for a single ultra-fine step and raises its lock flag. Turning step codes into oscillator control bits happens downstream.

Top module: `adgs_ctrl`

## Requirements
- R1: After reset, `req_vld`=0, `locked`=0, `req_step`=0 and `req_up`=1.
- R2: Cycles with `ph_vld`=0 are ignored. A window closes on the valid sample that brings its sample count to `win_len`, where `win_len`=0 counts as 1. Its outputs appear in the next cycle, and `req_vld` is high for that one cycle only.
- R3: A change of code is classified by the forward distance d=(new-old) mod NPH. A value 1 <= d < NPH/2 is a forward transition, and any other non-zero d is a backward transition. A wrap from NPH-1 to 0 is therefore one forward transition. The first valid sample after reset is not a transition.
- R4: `req_up` is 0 when forward transitions in the window outnumber backward ones, and 1 when backward transitions outnumber forward ones. On a tie, or when the window has no transitions, it takes the inverse of the most recent transition's direction (forward gives 0). Before any transition has occurred, that direction is backward.
- R5: A window whose total transition count is below `thr` is decided in low-gain mode, and otherwise in high-gain mode.
- R6: In high-gain mode the step code is 7 if total >= 4*thr, else 6 if total >= 2*thr, else 5.
- R7: A high-gain window with zero transitions (possible only with `thr`=0) issues no request.
- R8: A run counter counts consecutive valid samples with an unchanged code and saturates at 255. A transition captures the run and restarts it at 1. The low-gain width is the last run captured in the window. If the window has no transition, the width is the current run.
- R9: In low-gain mode without lock, the step code is 4 for width < 8, 3 for width < 32, 2 for width < 128, and 1 otherwise. A saturated width of 255 gives 1.
- R10: A low-gain window that has both forward and backward transitions gives step code 0 (a single ultra-fine step) and sets `locked`=1. `locked` is recomputed at every window close and held in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ph_vld | input | 1 | Phase code valid strobe |
| ph_code | input | 5 | Cyclic phase code, 0..NPH-1 |
| win_len | input | 16 | Measurement window length in valid samples |
| thr | input | 8 | Transition threshold between gain modes |
| req_vld | output | 1 | One-cycle pulse carrying a step request |
| req_up | output | 1 | 1 = raise frequency, 0 = lower |
| req_step | output | 3 | Step code: 0 ultra-fine, 1..4 small, 5..7 coarse |
| locked | output | 1 | Lock flag from the most recent window |

## Verification
The corner cases are these:
- A wrap from the top code to zero. A design that reads it as a large backward jump flips the request direction.
- A phase code held steady long enough to saturate the run counter. A design without saturation wraps to a small width and asks for the largest small step.
- A zero threshold with a steady code. A design that misses the R7 rule issues a spurious coarse request.
- A window length of zero or one, gaps of invalid samples, and windows that dither both ways. These catch a design that miscounts the window, counts idle cycles, or never declares lock.

// File: rtl/adgs_pkg.sv
// Shared types and step codes for the adaptive-gain search controller.
package adgs_pkg;

    // Classification of one valid sample's phase movement
    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_FWD  = 2'd1,
        DIR_BWD  = 2'd2
    } dir_e;

    localparam logic [2:0] STEP_ULTRA   = 3'd0;
    localparam logic [2:0] STEP_SMALL1  = 3'd1;
    localparam logic [2:0] STEP_COARSE0 = 3'd5;

endpackage

// File: rtl/adgs_phase_track.sv
// Phase tracker: classifies each valid phase code change as forward or
// backward by its shorter cyclic distance, and keeps a saturating run
// counter of samples spent in the current code.
// Assumes ph codes stay within 0..NPH-1.
module adgs_phase_track
    import adgs_pkg::*;
#(
    parameter int PH_W  = 5,
    parameter int NPH   = 20,
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic [PH_W-1:0]  code,
    output dir_e             dir,
    output logic [RUN_W-1:0] run_next,
    output logic [RUN_W-1:0] cap_width
);
    localparam int DW = PH_W + 1;
    localparam logic [DW-1:0]    NPH_V   = DW'(NPH);
    localparam logic [DW-1:0]    HALF_V  = DW'(NPH / 2);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [PH_W-1:0]  prev_q;
    logic             seen_q;
    logic [RUN_W-1:0] run_q;
    logic [DW-1:0]    delta;

    // Forward cyclic distance and direction of the current sample
    always_comb begin
        if ({1'b0, code} >= {1'b0, prev_q})
            delta = {1'b0, code} - {1'b0, prev_q};
        else
            delta = {1'b0, code} + NPH_V - {1'b0, prev_q};
        if (!vld || !seen_q || delta == '0)
            dir = DIR_NONE;
        else if (delta < HALF_V)
            dir = DIR_FWD;
        else
            dir = DIR_BWD;
    end

    // Run length after this sample, saturating at the counter maximum
    always_comb begin
        if (!vld)
            run_next = run_q;
        else if (!seen_q || dir != DIR_NONE)
            run_next = RUN_W'(1);
        else if (run_q == RUN_MAX)
            run_next = run_q;
        else
            run_next = run_q + RUN_W'(1);
    end

    assign cap_width = run_q;

    // Hold the last code and run length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            seen_q <= 1'b0;
            run_q  <= '0;
        end else if (vld) begin
            prev_q <= code;
            seen_q <= 1'b1;
            run_q  <= run_next;
        end
    end
endmodule

// File: rtl/adgs_win_accum.sv
// Window accumulator: counts valid samples up to the programmed window
// length and tallies forward/backward transitions and the latest phase
// width inside the window. Presents totals that include the current sample.
module adgs_win_accum
    import adgs_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  dir_e             dir,
    input  logic [RUN_W-1:0] run_next,
    input  logic [RUN_W-1:0] cap_width,
    input  logic [CNT_W-1:0] win_len,
    output logic             win_end,
    output logic [CNT_W-1:0] fwd_n,
    output logic [CNT_W-1:0] bwd_n,
    output logic [RUN_W-1:0] width_sel
);
    logic [CNT_W-1:0] wcnt_q, fwd_q, bwd_q, limit;
    logic [CNT_W:0]   cnt_n;
    logic             has_q, has_n;
    logic [RUN_W-1:0] wid_q, wid_n;

    // Window close detection with zero length treated as one
    always_comb begin
        limit   = (win_len == '0) ? CNT_W'(1) : win_len;
        cnt_n   = {1'b0, wcnt_q} + (CNT_W+1)'(1);
        win_end = vld && (cnt_n >= {1'b0, limit});
    end

    // Totals and width including the present sample
    always_comb begin
        fwd_n     = fwd_q + CNT_W'(dir == DIR_FWD);
        bwd_n     = bwd_q + CNT_W'(dir == DIR_BWD);
        has_n     = has_q || (dir != DIR_NONE);
        wid_n     = (dir != DIR_NONE) ? cap_width : wid_q;
        width_sel = has_n ? wid_n : run_next;
    end

    // Accumulate per window, clearing at its close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            fwd_q  <= '0;
            bwd_q  <= '0;
            has_q  <= 1'b0;
            wid_q  <= '0;
        end else if (vld) begin
            if (win_end) begin
                wcnt_q <= '0;
                fwd_q  <= '0;
                bwd_q  <= '0;
                has_q  <= 1'b0;
                wid_q  <= '0;
            end else begin
                wcnt_q <= cnt_n[CNT_W-1:0];
                fwd_q  <= fwd_n;
                bwd_q  <= bwd_n;
                has_q  <= has_n;
                wid_q  <= wid_n;
            end
        end
    end
endmodule

// File: rtl/adgs_step_pick.sv
// Step selector (combinational): picks the gain mode from the transition
// total, then runs a linear search for the step code over either the
// transition total (high gain) or the phase width (low gain).
module adgs_step_pick
    import adgs_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int THR_W  = 8,
    parameter int RUN_W  = 8,
    parameter int WBASE  = 8,
    parameter int HG_LVL = 3,
    parameter int LG_LVL = 4
) (
    input  logic [CNT_W-1:0] fwd,
    input  logic [CNT_W-1:0] bwd,
    input  logic [RUN_W-1:0] width,
    input  logic [THR_W-1:0] thr,
    input  logic             last_fwd,
    output logic             issue,
    output logic             up,
    output logic [2:0]       step,
    output logic             lock
);
    int   total;
    int   hg_idx;
    int   lg_idx;
    logic high;

    // Mode choice and linear searches over the two step ladders
    always_comb begin
        total  = int'(fwd) + int'(bwd);
        high   = total >= int'(thr);
        hg_idx = 0;
        for (int k = 1; k < HG_LVL; k++)
            if (total >= (int'(thr) << k)) hg_idx = k;
        lg_idx = 0;
        for (int k = 0; k < LG_LVL - 1; k++)
            if (int'(width) >= (WBASE << (2 * k))) lg_idx = k + 1;
        lock  = !high && fwd != '0 && bwd != '0;
        issue = !(high && total == 0);
        if (fwd > bwd)      up = 1'b0;
        else if (bwd > fwd) up = 1'b1;
        else                up = !last_fwd;
        if (high)      step = STEP_COARSE0 + 3'(hg_idx);
        else if (lock) step = STEP_ULTRA;
        else           step = STEP_SMALL1 + 3'(LG_LVL - 1 - lg_idx);
    end
endmodule

// File: rtl/adgs_ctrl.sv
// Adaptive-gain frequency search controller top. Ties the phase tracker,
// window accumulator and step selector together and registers one request
// per measurement window. Assumes one phase sample per valid strobe.
module adgs_ctrl
    import adgs_pkg::*;
#(
    parameter int PH_W  = 5,
    parameter int NPH   = 20,
    parameter int CNT_W = 16,
    parameter int THR_W = 8,
    parameter int RUN_W = 8,
    parameter int WBASE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ph_vld,
    input  logic [PH_W-1:0]  ph_code,
    input  logic [CNT_W-1:0] win_len,
    input  logic [THR_W-1:0] thr,
    output logic             req_vld,
    output logic             req_up,
    output logic [2:0]       req_step,
    output logic             locked
);
    dir_e             dir;
    logic [RUN_W-1:0] run_next, cap_width, width_sel;
    logic [CNT_W-1:0] fwd_n, bwd_n;
    logic             win_end, issue, up_c, lock_c, last_fwd_q, last_fwd_c;
    logic [2:0]       step_c;

    adgs_phase_track #(.PH_W(PH_W), .NPH(NPH), .RUN_W(RUN_W)) u_track (
        .clk(clk), .rst_n(rst_n), .vld(ph_vld), .code(ph_code),
        .dir(dir), .run_next(run_next), .cap_width(cap_width)
    );

    adgs_win_accum #(.CNT_W(CNT_W), .RUN_W(RUN_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .vld(ph_vld), .dir(dir),
        .run_next(run_next), .cap_width(cap_width), .win_len(win_len),
        .win_end(win_end), .fwd_n(fwd_n), .bwd_n(bwd_n), .width_sel(width_sel)
    );

    // Most recent transition direction, including this sample
    always_comb begin
        if (dir == DIR_FWD)      last_fwd_c = 1'b1;
        else if (dir == DIR_BWD) last_fwd_c = 1'b0;
        else                     last_fwd_c = last_fwd_q;
    end

    adgs_step_pick #(.CNT_W(CNT_W), .THR_W(THR_W), .RUN_W(RUN_W), .WBASE(WBASE)) u_pick (
        .fwd(fwd_n), .bwd(bwd_n), .width(width_sel), .thr(thr),
        .last_fwd(last_fwd_c), .issue(issue), .up(up_c), .step(step_c), .lock(lock_c)
    );

    // Register the request and lock flag at each window close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_vld    <= 1'b0;
            req_up     <= 1'b1;
            req_step   <= STEP_ULTRA;
            locked     <= 1'b0;
            last_fwd_q <= 1'b0;
        end else begin
            req_vld <= win_end && issue;
            if (ph_vld) last_fwd_q <= last_fwd_c;
            if (win_end) begin
                locked <= lock_c;
                if (issue) begin
                    req_up   <= up_c;
                    req_step <= step_c;
                end
            end
        end
    end
endmodule

// File: rtl/adgs_ctrl_chk.sv
// Checker for adgs_ctrl: temporal properties on the top-level ports.
module adgs_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ph_vld,
    input logic       req_vld,
    input logic       req_up,
    input logic [2:0] req_step,
    input logic       locked
);
    // R2: a request only follows a valid sample
    a_r2_req_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |-> $past(ph_vld));

    // R2: idle cycles leave the lock flag and request fields untouched
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ph_vld) |-> ($stable(locked) && $stable(req_step) && $stable(req_up)));

    // R10: lock goes with an ultra-fine step
    a_r10_lock_ultra: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && locked) |-> (req_step == 3'd0));

    // R10: an ultra-fine step is only requested in lock
    a_r10_ultra_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_step == 3'd0) |-> locked);

    // R6: coarse steps never coincide with lock
    a_r6_coarse_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_step >= 3'd5) |-> !locked);
endmodule

bind adgs_ctrl adgs_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ph_vld(ph_vld), .req_vld(req_vld),
    .req_up(req_up), .req_step(req_step), .locked(locked)
);

// File: tb/tb_adgs_ctrl.sv
module tb_adgs_ctrl;
    localparam int NPH = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ph_vld = 1'b0;
    logic [4:0]  ph_code = '0;
    logic [15:0] win_len = 16'd10;
    logic [7:0]  thr = 8'd10;
    logic        req_vld, req_up, locked;
    logic [2:0]  req_step;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state
    bit m_seen = 0;
    int m_prev = 0, m_run = 0, m_cnt = 0, m_f = 0, m_b = 0, m_wid = 0;
    bit m_has = 0, m_lastf = 0;
    bit e_vld = 0, e_up = 1, e_lock = 0, e_end = 0, e_zero_hg = 0;
    int e_step = 0;
    string e_tag = "R5";

    always #5 clk = ~clk;

    adgs_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ph_vld(ph_vld), .ph_code(ph_code),
        .win_len(win_len), .thr(thr), .req_vld(req_vld), .req_up(req_up),
        .req_step(req_step), .locked(locked)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model one cycle of the requirements
    task automatic model(input bit v, input int code);
        int d, t, w, lim, cap, dr;
        e_end = 0; e_vld = 0; e_zero_hg = 0;
        if (!v) return;
        dr = 0; cap = m_run;
        if (!m_seen) begin
            m_seen = 1; m_run = 1;
        end else begin
            d = (code - m_prev + NPH) % NPH;
            if (d == 0) m_run = (m_run < 255) ? m_run + 1 : 255;
            else begin
                dr = (d < NPH / 2) ? 1 : 2;
                m_run = 1;
            end
        end
        m_prev = code;
        m_cnt++;
        if (dr == 1) m_f++;
        if (dr == 2) m_b++;
        if (dr != 0) begin m_has = 1; m_wid = cap; m_lastf = (dr == 1); end
        lim = (win_len == 0) ? 1 : int'(win_len);
        if (m_cnt >= lim) begin
            e_end = 1;
            t = m_f + m_b;
            w = m_has ? m_wid : m_run;
            if (t >= int'(thr)) begin
                e_lock = 0;
                if (t == 0) e_zero_hg = 1;
                else begin
                    e_vld = 1;
                    e_step = (t >= 4 * int'(thr)) ? 7 : (t >= 2 * int'(thr)) ? 6 : 5;
                    e_tag = "R5 R6";
                end
            end else begin
                e_vld = 1;
                e_lock = (m_f > 0 && m_b > 0);
                if (e_lock) begin e_step = 0; e_tag = "R10"; end
                else begin
                    e_step = (w < 8) ? 4 : (w < 32) ? 3 : (w < 128) ? 2 : 1;
                    e_tag = "R5 R8 R9";
                end
            end
            if (e_vld) e_up = (m_f > m_b) ? 0 : (m_b > m_f) ? 1 : !m_lastf;
            m_cnt = 0; m_f = 0; m_b = 0; m_has = 0; m_wid = 0;
        end
    endtask

    task automatic sample(input bit v, input int code);
        @(negedge clk);
        ph_vld = v;
        ph_code = 5'(code);
        model(v, code);
        @(posedge clk);
        #1;
        check(e_zero_hg ? "R2 R7" : "R2", int'(req_vld), int'(e_vld));
        if (e_end) check("R10", int'(locked), int'(e_lock));
        if (e_vld) begin
            check("R3 R4", int'(req_up), int'(e_up));
            check(e_tag, int'(req_step), e_step);
        end
    endtask

    // Run one window of a stepping pattern: advance by adv every per samples
    task automatic run_window(input int len, input int th, input int per,
                              input int adv, input bit dither, input int gap,
                              inout int cur);
        int k;
        win_len = 16'(len);
        thr = 8'(th);
        k = 0;
        do begin
            if (gap > 0 && ($urandom % 100) < gap) sample(0, cur);
            else begin
                k++;
                if (per > 0 && (k % per) == 0) begin
                    if (dither) cur = (cur + (((k / per) % 2) ? 1 : NPH - 1)) % NPH;
                    else cur = (cur + adv + NPH) % NPH;
                end
                sample(1, cur);
            end
        end while (!e_end);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int cur;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset values
        check("R1", int'(req_vld), 0);
        check("R1", int'(locked), 0);
        check("R1", int'(req_step), 0);
        check("R1", int'(req_up), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 wrap from top code to zero counts forward
        cur = 18;
        run_window(4, 5, 1, 1, 0, 0, cur);
        // R10 dithering window declares lock
        run_window(8, 10, 1, 0, 1, 0, cur);
        // R8 R9 saturated width selects smallest step
        run_window(300, 1, 0, 0, 0, 0, cur);
        // R7 zero threshold, no movement: no request
        run_window(5, 0, 0, 0, 0, 0, cur);
        // R2 zero window length behaves as one, with gaps
        for (int i = 0; i < 6; i++) run_window(0, 3, 2, 1, 0, 30, cur);
        // R6 fast backward slew in high gain
        run_window(30, 4, 1, -1, 0, 0, cur);

        // Random windows
        for (int i = 0; i < 200; i++) begin
            int per, adv, len, th;
            len = 1 + ($urandom % 40);
            th = $urandom % 16;
            per = $urandom % 10;
            adv = (($urandom % 2) ? 1 : -1) * (1 + ($urandom % 3));
            run_window(len, th, per, adv, ($urandom % 4) == 0, 20, cur);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule